// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block caches mappings from virtual page numbers to physical page numbers. Every slot also holds an address-space tag, a global flag, one read-enable bit and one write-enable bit for each privilege mode, and two bits that force a fault on read and on write. A lookup is purely combinational. It takes a page number and the current address-space number, and in the same cycle it returns whether a slot hit, which slot it was, and that slot's fields. Permission evaluation is left to whatever sits downstream.

Four commands change the contents, and each takes effect at a clock edge. An insert always writes the slot named by a round-robin replacement pointer, whether or not that slot is occupied. A full flush empties the buffer. A process flush drops every entry that is not global. A page flush drops every entry that matches a given page, using the same address-space rule as a lookup.

Top module: `pgmap_tlb`

## Requirements
- R1: A slot hits only when it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored address-space number equals `lk_asn`.
- R2: An insert writes the slot that the replacement pointer names and replaces whatever that slot held, valid or not. The pointer then moves to the next slot and wraps from slot ENTRIES-1 back to slot 0.
- R3: An inserted slot becomes valid. Its tag is `ins_va >> PAGE_BITS`, so the page-offset bits of `ins_va` have no effect on the tag.
- R4: A full flush invalidates every slot, clears all their fields and sets the replacement pointer to 0. The next insert therefore goes to slot 0.
- R5: A process flush invalidates every valid slot whose global flag is clear. Global slots stay valid and unchanged.
- R6: A page flush invalidates every slot whose tag equals `fl_vpn` and whose address-space number equals `fl_asn` or whose global flag is set. A single command can clear several slots.
- R7: On a hit, `lk_idx`, `lk_ppn`, `lk_glob`, `lk_rd_en`, `lk_wr_en`, `lk_frd` and `lk_fwr` show the hitting slot. On a miss all of these outputs are 0.
- R8: When more than one slot hits, the slot with the lowest index is reported and `lk_multi` is 1. With one hit or none, `lk_multi` is 0.
- R9: Commands change state only at the rising clock edge. A lookup made in the same cycle as a command sees the contents from before that command.
- R10: After reset every slot is invalid and the replacement pointer is 0.
- R11: When several commands are asserted in the same cycle, only the highest-priority one takes effect. The order is `fl_all`, then `fl_proc`, then `fl_page`, then `ins_en`. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Page number to look up |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Some slot matched |
| lk_multi | output | 1 | More than one slot matched |
| lk_idx | output | IDX_W | Index of the reported slot |
| lk_ppn | output | PPN_W | Physical page of the reported slot |
| lk_glob | output | 1 | Global flag of the reported slot |
| lk_rd_en | output | MODES | Read enable per mode |
| lk_wr_en | output | MODES | Write enable per mode |
| lk_frd | output | 1 | Fault-on-read bit |
| lk_fwr | output | 1 | Fault-on-write bit |
| ins_en | input | 1 | Insert command |
| ins_va | input | VA_W | Virtual address supplying the tag |
| ins_ppn | input | PPN_W | Physical page to store |
| ins_asn | input | ASN_W | Address-space number to store |
| ins_glob | input | 1 | Global flag to store |
| ins_rd_en | input | MODES | Read enables to store |
| ins_wr_en | input | MODES | Write enables to store |
| ins_frd | input | 1 | Fault-on-read bit to store |
| ins_fwr | input | 1 | Fault-on-write bit to store |
| fl_all | input | 1 | Full flush command |
| fl_proc | input | 1 | Non-global flush command |
| fl_page | input | 1 | Page flush command |
| fl_vpn | input | VPN_W | Page to flush |
| fl_asn | input | ASN_W | Address-space number for the page flush |

## Verification
The assertions check on every cycle that a reported hit comes from a valid matching slot and that it is the lowest one. They also check how the replacement pointer steps and wraps, that a full flush leaves nothing valid, and that a process flush spares exactly the global slots. Only the bench scenarios can show the observable results. These are the field values returned after overwrites, the number of slots a page flush removes, whether the offset bits are ignored when forming the tag, what a lookup returns in the same cycle as a flush, and which command wins when several are asserted together.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_INSERT,
    CMD_PAGE,
    CMD_PROC,
    CMD_ALL
  } pgmap_cmd_e;

  // Next slot for the round-robin pointer, wrapping at n.
  function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Fixed priority among simultaneous commands.
  function automatic pgmap_cmd_e pick_cmd(input logic all, input logic proc,
                                          input logic page, input logic ins);
    if (all)  return CMD_ALL;
    if (proc) return CMD_PROC;
    if (page) return CMD_PAGE;
    if (ins)  return CMD_INSERT;
    return CMD_IDLE;
  endfunction

endpackage

// File: rtl/pgmap_match.sv
module pgmap_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0]            glob,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0][ASN_W-1:0] asns,
  input  logic [VPN_W-1:0]              req_vpn,
  input  logic [ASN_W-1:0]              req_asn,
  output logic [ENTRIES-1:0]            hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == req_vpn) &&
                     (glob[g] || (asns[g] == req_asn));
  end
endmodule

// File: rtl/pgmap_prio.sv
module pgmap_prio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic             multi,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    multi = ($countones(req) > 1);
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pgmap_rrptr.sv
module pgmap_rrptr
  import pgmap_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) ptr <= '0;
    else if (step)       ptr <= IDX_W'(wrap_inc(int'(ptr), N));
  end
endmodule

// File: rtl/pgmap_tlb.sv
module pgmap_tlb
  import pgmap_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 43,
  parameter int PAGE_BITS = 13,
  parameter int PPN_W     = 28,
  parameter int ASN_W     = 8,
  parameter int MODES     = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic             lk_multi,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_glob,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_frd,
  output logic             lk_fwr,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_glob,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_frd,
  input  logic             ins_fwr,
  input  logic             fl_all,
  input  logic             fl_proc,
  input  logic             fl_page,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [ASN_W-1:0] fl_asn
);

  logic [ENTRIES-1:0]            valid_q, glob_q, frd_q, fwr_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][ASN_W-1:0] asn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][MODES-1:0] rden_q, wren_q;

  // Named events for the checker
  pgmap_cmd_e         cmd;
  logic               ins_fire, fall_fire, fproc_fire, fpage_fire;
  logic [ENTRIES-1:0] look_hits, page_hits;
  logic [IDX_W-1:0]   slot_ptr;
  logic [VPN_W-1:0]   ins_tag;

  assign cmd        = pick_cmd(fl_all, fl_proc, fl_page, ins_en);
  assign ins_fire   = (cmd == CMD_INSERT);
  assign fall_fire  = (cmd == CMD_ALL);
  assign fproc_fire = (cmd == CMD_PROC);
  assign fpage_fire = (cmd == CMD_PAGE);
  assign ins_tag    = VPN_W'(ins_va >> PAGE_BITS);

  pgmap_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_look (
    .valid(valid_q), .glob(glob_q), .tags(tag_q), .asns(asn_q),
    .req_vpn(lk_vpn), .req_asn(lk_asn), .hits(look_hits)
  );

  pgmap_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_page (
    .valid(valid_q), .glob(glob_q), .tags(tag_q), .asns(asn_q),
    .req_vpn(fl_vpn), .req_asn(fl_asn), .hits(page_hits)
  );

  pgmap_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req(look_hits), .found(lk_hit), .multi(lk_multi), .idx(lk_idx)
  );

  pgmap_rrptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(fall_fire), .step(ins_fire), .ptr(slot_ptr)
  );

  // Read mux: fields of the reported slot, zero on a miss
  always_comb begin
    lk_ppn   = '0;
    lk_glob  = 1'b0;
    lk_rd_en = '0;
    lk_wr_en = '0;
    lk_frd   = 1'b0;
    lk_fwr   = 1'b0;
    if (lk_hit) begin
      lk_ppn   = ppn_q[lk_idx];
      lk_glob  = glob_q[lk_idx];
      lk_rd_en = rden_q[lk_idx];
      lk_wr_en = wren_q[lk_idx];
      lk_frd   = frd_q[lk_idx];
      lk_fwr   = fwr_q[lk_idx];
    end
  end

  // Slot storage
  always_ff @(posedge clk) begin
    if (!rst_n || fall_fire) begin
      valid_q <= '0;
      glob_q  <= '0;
      frd_q   <= '0;
      fwr_q   <= '0;
      tag_q   <= '0;
      asn_q   <= '0;
      ppn_q   <= '0;
      rden_q  <= '0;
      wren_q  <= '0;
    end else begin
      case (cmd)
        CMD_PROC:  valid_q <= valid_q & glob_q;
        CMD_PAGE:  valid_q <= valid_q & ~page_hits;
        CMD_INSERT: begin
          valid_q[slot_ptr] <= 1'b1;
          tag_q[slot_ptr]   <= ins_tag;
          asn_q[slot_ptr]   <= ins_asn;
          glob_q[slot_ptr]  <= ins_glob;
          ppn_q[slot_ptr]   <= ins_ppn;
          rden_q[slot_ptr]  <= ins_rd_en;
          wren_q[slot_ptr]  <= ins_wr_en;
          frd_q[slot_ptr]   <= ins_frd;
          fwr_q[slot_ptr]   <= ins_fwr;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pgmap_tlb_chk.sv
module pgmap_tlb_chk
  import pgmap_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_fire,
  input logic               fall_fire,
  input logic               fproc_fire,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] glob_q,
  input logic [ENTRIES-1:0] look_hits,
  input logic [IDX_W-1:0]   slot_ptr,
  input logic               lk_hit,
  input logic               lk_multi,
  input logic [IDX_W-1:0]   lk_idx
);
  logic [ENTRIES-1:0] below_idx;
  always_comb begin
    below_idx = '0;
    for (int i = 0; i < ENTRIES; i++) below_idx[i] = (i < int'(lk_idx));
  end

  AST_HIT_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q[lk_idx] && look_hits[lk_idx])); // R1
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((look_hits & below_idx) == '0)); // R8
  AST_SINGLE_NOT_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hits) |-> !lk_multi); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> (int'(slot_ptr) == int'(wrap_inc(int'($past(slot_ptr)), ENTRIES)))); // R2
  AST_INS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> valid_q[$past(slot_ptr)]); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fall_fire |=> (valid_q == '0 && slot_ptr == '0)); // R4
  AST_PROC_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    fproc_fire |=> (valid_q == ($past(valid_q) & $past(glob_q)))); // R5
endmodule

bind pgmap_tlb pgmap_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/pgmap_tlb_test.sv
module pgmap_tlb_test;
  localparam int E = 4, VA_W = 16, PB = 8, PPN_W = 8, ASN_W = 2, MODES = 4;
  localparam int VPN_W = VA_W - PB, IDX_W = 2;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk; // 125 MHz

  logic [VPN_W-1:0] lk_vpn = '0, fl_vpn = '0;
  logic [ASN_W-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0;
  logic lk_hit, lk_multi, lk_glob, lk_frd, lk_fwr;
  logic [IDX_W-1:0] lk_idx;
  logic [PPN_W-1:0] lk_ppn, ins_ppn = '0;
  logic [MODES-1:0] lk_rd_en, lk_wr_en, ins_rd_en = '0, ins_wr_en = '0;
  logic ins_en = 0, ins_glob = 0, ins_frd = 0, ins_fwr = 0;
  logic [VA_W-1:0] ins_va = '0;
  logic fl_all = 0, fl_proc = 0, fl_page = 0;

  pgmap_tlb #(.ENTRIES(E), .VA_W(VA_W), .PAGE_BITS(PB), .PPN_W(PPN_W),
              .ASN_W(ASN_W), .MODES(MODES)) uut (.*);

  int nvec = 0, nbad = 0;
  int m_valid[E], m_tag[E], m_asn[E], m_glob[E], m_ppn[E], m_rd[E], m_wr[E], m_frd[E], m_fwr[E];
  int m_ptr = 0;

  task automatic look(input int v, input int a, input string rq);
    int cnt, idx, eppn, eg, erd, ewr, efr, efw;
    cnt = 0; idx = -1;
    lk_vpn = VPN_W'(v); lk_asn = ASN_W'(a);
    #1;
    for (int i = 0; i < E; i++)
      if (m_valid[i] != 0 && m_tag[i] == v && (m_glob[i] != 0 || m_asn[i] == a)) begin
        cnt++;
        if (idx < 0) idx = i;
      end
    if (idx < 0) begin eppn = 0; eg = 0; erd = 0; ewr = 0; efr = 0; efw = 0; end
    else begin
      eppn = m_ppn[idx]; eg = m_glob[idx]; erd = m_rd[idx]; ewr = m_wr[idx];
      efr = m_frd[idx]; efw = m_fwr[idx];
    end
    nvec++;
    if (lk_hit !== (cnt > 0) || lk_multi !== (cnt > 1) ||
        int'(lk_idx) != (idx < 0 ? 0 : idx) || int'(lk_ppn) != eppn ||
        int'(lk_glob) != eg || int'(lk_rd_en) != erd || int'(lk_wr_en) != ewr ||
        int'(lk_frd) != efr || int'(lk_fwr) != efw) begin
      nbad++;
      $display("FAIL %s vpn=%0d asn=%0d actual hit=%0b multi=%0b idx=%0d ppn=%0h expected hit=%0b multi=%0b idx=%0d ppn=%0h",
               rq, v, a, lk_hit, lk_multi, lk_idx, lk_ppn, cnt > 0, cnt > 1, idx, eppn);
    end
  endtask

  task automatic sweep(input string rq);
    for (int v = 0; v < 8; v++)
      for (int a = 0; a < 4; a++) look(v, a, rq);
  endtask

  // Apply whatever commands are driven for one edge and update the model.
  task automatic pulse();
    @(posedge clk);
    if (fl_all) begin
      for (int i = 0; i < E; i++) begin
        m_valid[i] = 0; m_tag[i] = 0; m_asn[i] = 0; m_glob[i] = 0; m_ppn[i] = 0;
        m_rd[i] = 0; m_wr[i] = 0; m_frd[i] = 0; m_fwr[i] = 0;
      end
      m_ptr = 0;
    end else if (fl_proc) begin
      for (int i = 0; i < E; i++) if (m_glob[i] == 0) m_valid[i] = 0;
    end else if (fl_page) begin
      for (int i = 0; i < E; i++)
        if (m_tag[i] == int'(fl_vpn) && (m_glob[i] != 0 || m_asn[i] == int'(fl_asn)))
          m_valid[i] = 0;
    end else if (ins_en) begin
      m_valid[m_ptr] = 1; m_tag[m_ptr] = int'(ins_va) / 256; m_asn[m_ptr] = int'(ins_asn);
      m_glob[m_ptr] = int'(ins_glob); m_ppn[m_ptr] = int'(ins_ppn);
      m_rd[m_ptr] = int'(ins_rd_en); m_wr[m_ptr] = int'(ins_wr_en);
      m_frd[m_ptr] = int'(ins_frd); m_fwr[m_ptr] = int'(ins_fwr);
      m_ptr = (m_ptr + 1) % E;
    end
    @(negedge clk);
    ins_en = 0; fl_all = 0; fl_proc = 0; fl_page = 0;
  endtask

  task automatic put(input int va, input int ppn, input int asn, input int g,
                     input int rd, input int wr, input int fr, input int fw);
    ins_en = 1; ins_va = VA_W'(va); ins_ppn = PPN_W'(ppn); ins_asn = ASN_W'(asn);
    ins_glob = g[0]; ins_rd_en = MODES'(rd); ins_wr_en = MODES'(wr);
    ins_frd = fr[0]; ins_fwr = fw[0];
  endtask

  initial begin
    #(8 * 100000);
    nbad++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < E; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_asn[i] = 0; m_glob[i] = 0; m_ppn[i] = 0;
      m_rd[i] = 0; m_wr[i] = 0; m_frd[i] = 0; m_fwr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R10");
    // R1 R3 R7 R8: offset bits set, duplicate tag in slot 2
    put('h0312, 'h41, 1, 0, 'b0011, 'b0001, 0, 1); pulse();
    put('h05FF, 'h52, 2, 1, 'b1111, 'b0000, 1, 0); pulse();
    put('h0300, 'h63, 1, 0, 'b0100, 'b1000, 1, 1); pulse();
    put('h07AB, 'h74, 3, 0, 'b1010, 'b0101, 0, 0); pulse();
    sweep("R1_R3_R7_R8");
    // R2: fifth insert wraps and replaces slot 0
    put('h0200, 'h85, 0, 0, 'b0001, 'b0010, 0, 1); pulse();
    sweep("R2");
    put('h0600, 'h96, 2, 0, 'b0110, 'b0110, 1, 0); pulse();
    sweep("R2");
    // R4: full flush, then insert lands in slot 0
    fl_all = 1; pulse();
    sweep("R4");
    put('h0500, 'h11, 1, 0, 'b0001, 'b0001, 0, 0); pulse();
    put('h0501, 'h22, 2, 1, 'b0010, 'b0010, 0, 0); pulse();
    put('h0502, 'h33, 3, 0, 'b0100, 'b0100, 0, 0); pulse();
    put('h0600, 'h44, 1, 0, 'b1000, 'b1000, 0, 0); pulse();
    sweep("R4");
    // R6: page flush clears the asn match and the global one
    fl_page = 1; fl_vpn = VPN_W'(5); fl_asn = ASN_W'(1); pulse();
    sweep("R6");
    // R5
    fl_all = 1; pulse();
    put('h0100, 'h51, 0, 1, 'b0011, 'b0000, 0, 0); pulse();
    put('h0200, 'h62, 1, 0, 'b0101, 'b0000, 0, 0); pulse();
    put('h0400, 'h73, 2, 1, 'b1001, 'b0000, 0, 0); pulse();
    put('h0600, 'h84, 3, 0, 'b1111, 'b0000, 0, 0); pulse();
    fl_proc = 1; pulse();
    sweep("R5");
    // R9: lookup in the same cycle as a flush sees old contents
    fl_all = 1;
    look(1, 3, "R9");
    look(4, 0, "R9");
    pulse();
    sweep("R9");
    // R11: priority among simultaneous commands
    put('h0300, 'h91, 0, 0, 'b0001, 'b0001, 0, 0); pulse();
    put('h0301, 'hA2, 1, 1, 'b0010, 'b0010, 0, 0); pulse();
    put('h0700, 'hB3, 2, 0, 'b0100, 'b0100, 0, 0); fl_proc = 1; pulse();
    sweep("R11");
    put('h0700, 'hC4, 2, 0, 'b0100, 'b0100, 0, 0);
    fl_page = 1; fl_vpn = VPN_W'(3); fl_asn = ASN_W'(0); pulse();
    sweep("R11");
    put('h0400, 'hD5, 0, 0, 'b0001, 'b0001, 0, 0); pulse();
    fl_all = 1; fl_proc = 1; fl_page = 1; fl_vpn = VPN_W'(4); pulse();
    sweep("R11");
    put('h0100, 'hE6, 1, 0, 'b0001, 'b0001, 0, 0); pulse();
    sweep("R11");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule